// File: doc/BRIEF.md
# Multi-channel sequential break unit

The unit watches a CPU's data bus and its instruction stream through five match channels and produces a one-cycle halt request for a debug controller. Channels 1 to 4 compare either the bus address or an instruction's program counter against a programmed value under a don't-care mask. They can also qualify on the current address-space ID, on the transfer direction and on the bus state code. Only channel 1 can also compare bus data, selecting the byte lane from the low address bits and filtering on access size. Only channels 1 and 2 can choose whether a PC match counts when the instruction issues or when it retires. Channel 5 is an event channel. It fires on either a TLB-load instruction strobe or an internal I/O access strobe.

A chain sequencer can bind channels 1 to 4 into an ordered chain: 2 then 1, 3 then 2 then 1, or 4 then 3 then 2 then 1. A chained channel arms only after the previous stage has hit. The halt request for the chain is raised only when channel 1 hits in the last stage. Channels outside the chain still break on their own. Every halt request comes with a status word that records its cause. That word is held until the next halt.

Configuration is written one word per cycle through a small register port. Register index (cfg_addr): 0 ch1 control, 1 ch1 address, 2 ch1 address mask, 3 ch1 data, 4 ch1 data mask, 5/6/7 ch2 control/address/mask, 8/9/10 ch3, 11/12/13 ch4, 14 ch5 control, 15 chain mode. The channel control word for channels 1 to 4 has these fields: bit0 enable, bit1 PC source (0 = bus address), bit2 retire phase, bits4:3 direction (1 read only, 2 write only, other any), bit5 ASID check, bits13:6 ASID value, bit14 state check, bits16:15 state value, bits18:17 size (0 any, 1 byte, 2 word, 3 longword), bit19 data check. The ch5 control word has bit0 enable and bit1 kind (0 TLB load, 1 I/O access). The chain mode word uses bits1:0: 0 off, 1 = 2→1, 2 = 3→2→1, 3 = 4→3→2→1. A mask bit of 1 means don't care.

Top module: `brk_seq_unit`

## Requirements
- R1: A channel among 1 to 4 with PC source 0 hits on a bus cycle (bus_valid) when the address matches its value on every bit whose mask bit is 0.
- R2: With PC source 1, a channel hits on ins_valid when ins_pc matches under the mask. Channels 1 and 2 count only instructions whose ins_after equals their retire-phase bit. Channels 3 and 4 count only issue-phase instructions (ins_after 0).
- R3: Channel 1 has a size field. When that field is nonzero, bus_size (0 byte, 1 word, 2 longword) must equal size minus one. With the data check on, the selected lane is compared against the data value under the data mask. A byte access takes bus_data byte bus_addr[1:0], a word access takes halfword bus_addr[1], and a longword takes all 32 bits. Size and data fields have no effect on channels 2 to 4.
- R4: Direction 1 rejects writes, direction 2 rejects reads, an enabled ASID check requires cur_asid to equal the ASID value, and an enabled state check requires bus_state to equal the state value.
- R5: Channel 5, when enabled, hits on tlb_load if its kind is 0 and on io_access if its kind is 1.
- R6: With the chain off, any channel hit in a cycle gives halt_req high for exactly the next cycle. In that same cycle, brk_status[4:0] holds the hitting channels (bit i = channel i+1) and brk_status[5] is 0. Status is zero after reset and is otherwise held between halts.
- R7: In a chain mode, the halt for the chain is raised only after the chained channels hit in descending order, ending with channel 1. On that halt, brk_status[5] is 1.
- R8: A hit on a chained channel that is not the one the current stage expects is ignored and does not advance or restart the chain.
- R9: The chain returns to its first stage after any halt and on a write to the chain mode register.
- R10: hit_flags shows, one cycle later, every channel's raw match, whatever the chain state. Channels outside the active chain still raise a halt on their own.
- R11: A channel whose enable bit is 0 never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| bus_valid | input | 1 | Bus cycle present this clock |
| bus_addr | input | 32 | Bus address |
| bus_data | input | 32 | Bus data, lane-aligned |
| bus_size | input | 2 | Access size: 0 byte, 1 word, 2 longword |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_state | input | 2 | Bus operating state code |
| cur_asid | input | 8 | Current address-space ID |
| ins_valid | input | 1 | Instruction event present |
| ins_pc | input | 32 | Program counter of the instruction |
| ins_after | input | 1 | 0 issue phase, 1 retire phase |
| tlb_load | input | 1 | TLB-load instruction executed |
| io_access | input | 1 | Internal I/O region accessed |
| halt_req | output | 1 | One-cycle halt request |
| hit_flags | output | 5 | Per-channel raw match, registered |
| brk_status | output | 6 | Cause of the latest halt |

## Verification
The hardest situation to reach from the ports is a four-stage chain that completes while misordered hits are mixed in. A random stream rarely produces that, because each stage needs its own channel to match at the right moment and no independent channel may break the chain first. Directed sequences reach it by giving each chained channel a distinct address and presenting out-of-order hits between the ordered ones. They also rewrite the mode register in the middle of a chain. Random traffic then draws addresses, PCs, ASIDs and data bytes from small pools that overlap the programmed values, so masked, lane-selected and qualified matches occur often. All of it is compared cycle by cycle against a model of the requirements.

// File: rtl/brk_pkg.sv
package brk_pkg;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int ASID_W  = 8;
    localparam int STATE_W = 2;
    localparam int N_SEQ   = 4;
    localparam int N_CH    = N_SEQ + 1;
    localparam int CFG_AW  = 4;
    localparam int STAGE_W = $clog2(N_SEQ);
    localparam int CAUSE_W = N_CH + 1;
    localparam int EV_REG  = 14;
    localparam int SEQ_REG = 15;

    typedef enum logic [1:0] {
        SEQ_OFF = 2'd0,
        SEQ_2_1 = 2'd1,
        SEQ_3_1 = 2'd2,
        SEQ_4_1 = 2'd3
    } seq_mode_e;

    typedef struct packed {
        logic               data_chk;
        logic [1:0]         size;
        logic [STATE_W-1:0] state_val;
        logic               state_chk;
        logic [ASID_W-1:0]  asid_val;
        logic               asid_chk;
        logic [1:0]         dir;
        logic               after_exec;
        logic               use_pc;
        logic               en;
    } chan_ctrl_t;

    localparam int CTRL_W = $bits(chan_ctrl_t);

    function automatic int chan_base(int idx);
        return (idx == 0) ? 0 : (5 + 3 * (idx - 1));
    endfunction
endpackage

// File: rtl/brk_match_chan.sv
module brk_match_chan
    import brk_pkg::*;
#(
    parameter int HAS_DATA   = 0,
    parameter int HAS_TIMING = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_ctrl,
    input  logic               we_addr,
    input  logic               we_amask,
    input  logic               we_dval,
    input  logic               we_dmask,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               bus_valid,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_data,
    input  logic [1:0]         bus_size,
    input  logic               bus_wr,
    input  logic [STATE_W-1:0] bus_state,
    input  logic [ASID_W-1:0]  cur_asid,
    input  logic               ins_valid,
    input  logic [ADDR_W-1:0]  ins_pc,
    input  logic               ins_after,
    output logic               hit
);
    typedef struct packed {
        chan_ctrl_t        ctrl;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] amask;
        logic [DATA_W-1:0] dval;
        logic [DATA_W-1:0] dmask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_ctrl)  cfg_d.ctrl  = chan_ctrl_t'(wdata[CTRL_W-1:0]);
        if (we_addr)  cfg_d.addr  = wdata[ADDR_W-1:0];
        if (we_amask) cfg_d.amask = wdata[ADDR_W-1:0];
        if (HAS_DATA != 0 && we_dval)  cfg_d.dval  = wdata;
        if (HAS_DATA != 0 && we_dmask) cfg_d.dmask = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    logic              asid_ok, dir_ok, state_ok, size_ok, data_ok;
    logic              pc_ok, bus_ok, phase_want;
    logic [DATA_W-1:0] lane_data, lane_mask;
    logic [1:0]        size_m1;

    always_comb begin
        asid_ok  = !cfg_q.ctrl.asid_chk || (cur_asid == cfg_q.ctrl.asid_val);
        state_ok = !cfg_q.ctrl.state_chk || (bus_state == cfg_q.ctrl.state_val);
        unique case (cfg_q.ctrl.dir)
            2'd1:    dir_ok = !bus_wr;
            2'd2:    dir_ok = bus_wr;
            default: dir_ok = 1'b1;
        endcase

        unique case (bus_size)
            2'd0: begin
                lane_data = bus_data >> {bus_addr[1:0], 3'b000};
                lane_mask = DATA_W'(32'h0000_00FF);
            end
            2'd1: begin
                lane_data = bus_data >> {bus_addr[1], 4'b0000};
                lane_mask = DATA_W'(32'h0000_FFFF);
            end
            default: begin
                lane_data = bus_data;
                lane_mask = '1;
            end
        endcase

        size_m1 = cfg_q.ctrl.size - 2'd1;
        size_ok = 1'b1;
        data_ok = 1'b1;
        if (HAS_DATA != 0) begin
            size_ok = (cfg_q.ctrl.size == 2'd0) || (bus_size == size_m1);
            data_ok = !cfg_q.ctrl.data_chk ||
                      (((lane_data ^ cfg_q.dval) & lane_mask & ~cfg_q.dmask) == '0);
        end

        phase_want = (HAS_TIMING != 0) ? cfg_q.ctrl.after_exec : 1'b0;
        pc_ok  = cfg_q.ctrl.use_pc && ins_valid && (ins_after == phase_want) &&
                 (((ins_pc ^ cfg_q.addr) & ~cfg_q.amask) == '0);
        bus_ok = !cfg_q.ctrl.use_pc && bus_valid &&
                 (((bus_addr ^ cfg_q.addr) & ~cfg_q.amask) == '0) &&
                 dir_ok && state_ok && size_ok && data_ok;
        hit    = cfg_q.ctrl.en && asid_ok && (pc_ok || bus_ok);
    end
endmodule

// File: rtl/brk_event_chan.sv
module brk_event_chan (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [1:0] wdata,
    input  logic       tlb_load,
    input  logic       io_access,
    output logic       hit
);
    typedef struct packed {
        logic kind;
        logic en;
    } ev_ctrl_t;

    ev_ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (we) ctrl_d = ev_ctrl_t'(wdata);
        hit = ctrl_q.en && (ctrl_q.kind ? io_access : tlb_load);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end
endmodule

// File: rtl/brk_chain_seq.sv
module brk_chain_seq
    import brk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_we,
    input  logic [1:0]         mode_wdata,
    input  logic [N_CH-1:0]    hit,
    output logic               brk,
    output logic [CAUSE_W-1:0] cause
);
    typedef struct packed {
        seq_mode_e          mode;
        logic [STAGE_W-1:0] stage;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic [N_SEQ-1:0]   chain_mask;
    logic [N_CH-1:0]    indep;
    logic [STAGE_W-1:0] want_idx;
    logic               chain_on, advance, done;

    always_comb begin
        chain_on = (st_q.mode != SEQ_OFF);
        for (int i = 0; i < N_SEQ; i++)
            chain_mask[i] = chain_on && (i <= int'(st_q.mode));
        want_idx = STAGE_W'(st_q.mode) - st_q.stage;
        advance  = chain_on && hit[want_idx];
        done     = chain_on && (st_q.stage == STAGE_W'(st_q.mode)) && hit[0];
        indep    = hit & ~{1'b0, chain_mask};
        brk      = (|indep) || done;
        cause    = {done, indep};

        st_d = st_q;
        if (mode_we) st_d.mode = seq_mode_e'(mode_wdata);
        if (mode_we || brk)  st_d.stage = '0;
        else if (advance)    st_d.stage = st_q.stage + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: SEQ_OFF, stage: '0};
        else        st_q <= st_d;
    end

    // R9
    seq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we || brk) |=> (st_q.stage == '0));

    // R7
    stage_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stage <= STAGE_W'(st_q.mode));

    // R8
    stage_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stage != $past(st_q.stage)) |->
        ((st_q.stage == '0) || (st_q.stage == STAGE_W'($past(st_q.stage) + 1'b1))));
endmodule

// File: rtl/brk_seq_unit.sv
module brk_seq_unit
    import brk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    input  logic               bus_valid,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_data,
    input  logic [1:0]         bus_size,
    input  logic               bus_wr,
    input  logic [STATE_W-1:0] bus_state,
    input  logic [ASID_W-1:0]  cur_asid,
    input  logic               ins_valid,
    input  logic [ADDR_W-1:0]  ins_pc,
    input  logic               ins_after,
    input  logic               tlb_load,
    input  logic               io_access,
    output logic               halt_req,
    output logic [N_CH-1:0]    hit_flags,
    output logic [CAUSE_W-1:0] brk_status
);
    logic [N_CH-1:0]    raw_hit;
    logic               brk;
    logic [CAUSE_W-1:0] cause;

    for (genvar gi = 0; gi < N_SEQ; gi++) begin : g_chan
        localparam int BASE = chan_base(gi);
        brk_match_chan #(
            .HAS_DATA  ((gi == 0) ? 1 : 0),
            .HAS_TIMING((gi < 2) ? 1 : 0)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .we_ctrl   (cfg_wr && cfg_addr == CFG_AW'(BASE)),
            .we_addr   (cfg_wr && cfg_addr == CFG_AW'(BASE + 1)),
            .we_amask  (cfg_wr && cfg_addr == CFG_AW'(BASE + 2)),
            .we_dval   ((gi == 0) && cfg_wr && cfg_addr == CFG_AW'(BASE + 3)),
            .we_dmask  ((gi == 0) && cfg_wr && cfg_addr == CFG_AW'(BASE + 4)),
            .wdata     (cfg_wdata),
            .bus_valid (bus_valid),
            .bus_addr  (bus_addr),
            .bus_data  (bus_data),
            .bus_size  (bus_size),
            .bus_wr    (bus_wr),
            .bus_state (bus_state),
            .cur_asid  (cur_asid),
            .ins_valid (ins_valid),
            .ins_pc    (ins_pc),
            .ins_after (ins_after),
            .hit       (raw_hit[gi])
        );
    end

    brk_event_chan u_event (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_wr && cfg_addr == CFG_AW'(EV_REG)),
        .wdata     (cfg_wdata[1:0]),
        .tlb_load  (tlb_load),
        .io_access (io_access),
        .hit       (raw_hit[N_CH-1])
    );

    brk_chain_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (cfg_wr && cfg_addr == CFG_AW'(SEQ_REG)),
        .mode_wdata (cfg_wdata[1:0]),
        .hit        (raw_hit),
        .brk        (brk),
        .cause      (cause)
    );

    typedef struct packed {
        logic               halt;
        logic [N_CH-1:0]    hit;
        logic [CAUSE_W-1:0] status;
    } out_st_t;

    out_st_t out_d, out_q;

    always_comb begin
        out_d.halt   = brk;
        out_d.hit    = raw_hit;
        out_d.status = brk ? cause : out_q.status;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign halt_req   = out_q.halt;
    assign hit_flags  = out_q.hit;
    assign brk_status = out_q.status;

    // R6
    halt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> (brk_status != '0));

    // R5
    event_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_flags[N_CH-1] |-> $past(tlb_load || io_access));
endmodule

// File: tb/tb_brk_seq_unit.sv
module tb_brk_seq_unit;
    import brk_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_data = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_state = '0;
    logic [7:0]  cur_asid = '0;
    logic        ins_valid = 1'b0;
    logic [31:0] ins_pc = '0;
    logic        ins_after = 1'b0;
    logic        tlb_load = 1'b0;
    logic        io_access = 1'b0;
    logic        halt_req;
    logic [4:0]  hit_flags;
    logic [5:0]  brk_status;

    always #(CLK_PERIOD / 2) clk = ~clk;

    brk_seq_unit dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_size(bus_size), .bus_wr(bus_wr),
        .bus_state(bus_state), .cur_asid(cur_asid), .ins_valid(ins_valid),
        .ins_pc(ins_pc), .ins_after(ins_after), .tlb_load(tlb_load),
        .io_access(io_access), .halt_req(halt_req), .hit_flags(hit_flags),
        .brk_status(brk_status)
    );

    logic [31:0] sh_ctrl [5];
    logic [31:0] sh_addr [4];
    logic [31:0] sh_amask[4];
    logic [31:0] sh_dval, sh_dmask;
    logic [1:0]  sh_mode;
    int          m_stage;
    logic        e_halt;
    logic [4:0]  e_hit;
    logic [5:0]  e_status;
    int          n_vec = 0;
    int          n_bad = 0;

    function automatic logic [31:0] mk_ctrl(bit en, bit use_pc, bit after, bit [1:0] dir,
                                            bit achk, bit [7:0] aval, bit schk, bit [1:0] sval,
                                            bit [1:0] size, bit dchk);
        return {12'd0, dchk, size, sval, schk, aval, achk, dir, after, use_pc, en};
    endfunction

    function automatic logic model_hit(int i);
        logic [31:0] c, got, wm;
        logic [1:0]  sz;
        if (i == 4) return sh_ctrl[4][0] && (sh_ctrl[4][1] ? io_access : tlb_load);
        c = sh_ctrl[i];
        if (!c[0]) return 1'b0;                                   // R11
        if (c[5] && cur_asid != c[13:6]) return 1'b0;             // R4
        if (c[1])                                                 // R2
            return ins_valid && (ins_after == ((i < 2) ? c[2] : 1'b0)) &&
                   (((ins_pc ^ sh_addr[i]) & ~sh_amask[i]) == 0);
        if (!bus_valid) return 1'b0;
        if (((bus_addr ^ sh_addr[i]) & ~sh_amask[i]) != 0) return 1'b0; // R1
        if (c[4:3] == 2'd1 && bus_wr) return 1'b0;
        if (c[4:3] == 2'd2 && !bus_wr) return 1'b0;
        if (c[14] && bus_state != c[16:15]) return 1'b0;
        if (i == 0) begin                                         // R3
            sz = c[18:17];
            if (sz != 0 && bus_size != sz - 2'd1) return 1'b0;
            if (c[19]) begin
                if (bus_size == 0) begin
                    got = (bus_data >> (8 * bus_addr[1:0])) & 32'hFF; wm = 32'hFF;
                end else if (bus_size == 1) begin
                    got = (bus_data >> (16 * bus_addr[1])) & 32'hFFFF; wm = 32'hFFFF;
                end else begin
                    got = bus_data; wm = 32'hFFFF_FFFF;
                end
                if (((got ^ sh_dval) & wm & ~sh_dmask) != 0) return 1'b0;
            end
        end
        return 1'b1;
    endfunction

    task automatic tick(string req);
        logic [4:0] h, cm, indep;
        logic       done, brk, mwe;
        int         want;
        for (int i = 0; i < 5; i++) h[i] = model_hit(i);
        cm = '0;
        if (sh_mode != 0) for (int i = 0; i <= int'(sh_mode); i++) cm[i] = 1'b1;
        indep = h & ~cm;
        want  = int'(sh_mode) - m_stage;
        done  = (sh_mode != 0) && (m_stage == int'(sh_mode)) && h[0];
        brk   = (|indep) || done;
        mwe   = cfg_wr && cfg_addr == 4'd15;
        e_halt = brk;
        e_hit  = h;
        if (brk) e_status = {done, indep};
        if (mwe || brk) m_stage = 0;
        else if (sh_mode != 0 && h[want]) m_stage = m_stage + 1;
        if (cfg_wr) begin
            case (cfg_addr)
                4'd0: sh_ctrl[0] = cfg_wdata & 32'hF_FFFF;
                4'd1: sh_addr[0] = cfg_wdata;
                4'd2: sh_amask[0] = cfg_wdata;
                4'd3: sh_dval = cfg_wdata;
                4'd4: sh_dmask = cfg_wdata;
                4'd5, 4'd8, 4'd11: sh_ctrl[(cfg_addr - 2) / 3] = cfg_wdata & 32'hF_FFFF;
                4'd6, 4'd9, 4'd12: sh_addr[(cfg_addr - 3) / 3] = cfg_wdata;
                4'd7, 4'd10, 4'd13: sh_amask[(cfg_addr - 4) / 3] = cfg_wdata;
                4'd14: sh_ctrl[4] = cfg_wdata & 32'h3;
                default: sh_mode = cfg_wdata[1:0];
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (halt_req !== e_halt || hit_flags !== e_hit || brk_status !== e_status) begin
            n_bad++;
            $display("FAIL %s: halt=%b hit=%b status=%b expected halt=%b hit=%b status=%b",
                     req, halt_req, hit_flags, brk_status, e_halt, e_hit, e_status);
        end
    endtask

    task automatic idle();
        cfg_wr = 0; bus_valid = 0; ins_valid = 0; tlb_load = 0; io_access = 0;
        bus_wr = 0; bus_size = 2'd2; bus_state = 0; ins_after = 0;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d, string req);
        idle();
        cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
        tick(req);
        cfg_wr = 0;
    endtask

    task automatic bus(logic [31:0] a, logic [31:0] d, logic [1:0] sz, logic w, string req);
        idle();
        bus_valid = 1; bus_addr = a; bus_data = d; bus_size = sz; bus_wr = w;
        tick(req);
    endtask

    task automatic pc(logic [31:0] p, logic after, string req);
        idle();
        ins_valid = 1; ins_pc = p; ins_after = after;
        tick(req);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    function automatic logic [31:0] pool_addr();
        return 32'h4000_0000 + (($urandom % 8) << 2) + ($urandom % 4);
    endfunction

    function automatic logic [31:0] rand_reg(logic [3:0] a);
        logic [31:0] r = $urandom;
        case (a)
            4'd0, 4'd5, 4'd8, 4'd11: begin
                r = r & 32'hF_FFFF;
                r[13:6] = 8'($urandom % 2);
                r[0] = ($urandom % 4) != 0;
                return r;
            end
            4'd2, 4'd7, 4'd10, 4'd13, 4'd4: begin
                case ($urandom % 4)
                    0: return 32'h0;
                    1: return 32'h3;
                    2: return 32'hC;
                    default: return 32'hFF;
                endcase
            end
            4'd3: return 32'($urandom % 4) * 32'h11;
            4'd14, 4'd15: return r & 32'h3;
            default: return pool_addr();
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog R6: run did not finish, actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 5; i++) sh_ctrl[i] = '0;
        for (int i = 0; i < 4; i++) begin sh_addr[i] = '0; sh_amask[i] = '0; end
        sh_dval = '0; sh_dmask = '0; sh_mode = '0; m_stage = 0;
        e_halt = 0; e_hit = '0; e_status = '0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        n_vec++;
        if (halt_req !== 1'b0 || hit_flags !== 5'd0 || brk_status !== 6'd0) begin
            n_bad++;
            $display("FAIL R6 reset: halt=%b hit=%b status=%b expected 0 0 0",
                     halt_req, hit_flags, brk_status);
        end

        // R1: masked bus address on channel 3
        wr(4'd9, 32'h2000_0040, "R1");
        wr(4'd10, 32'h0000_000F, "R1");
        wr(4'd8, mk_ctrl(1,0,0,0,0,0,0,0,0,0), "R1");
        bus(32'h2000_004C, 0, 2, 0, "R1");
        bus(32'h2000_0050, 0, 2, 0, "R1");
        // R11: disabled channel
        wr(4'd8, mk_ctrl(0,0,0,0,0,0,0,0,0,0), "R11");
        bus(32'h2000_004C, 0, 2, 0, "R11");

        // R2: channel 1 retire phase, channel 3 issue only
        wr(4'd1, 32'h0000_1000, "R2");
        wr(4'd2, 32'h0, "R2");
        wr(4'd0, mk_ctrl(1,1,1,0,0,0,0,0,0,0), "R2");
        pc(32'h0000_1000, 0, "R2");
        pc(32'h0000_1000, 1, "R2");
        wr(4'd9, 32'h0000_2000, "R2");
        wr(4'd10, 32'h0, "R2");
        wr(4'd8, mk_ctrl(1,1,1,0,0,0,0,0,0,0), "R2");
        pc(32'h0000_2000, 1, "R2");
        pc(32'h0000_2000, 0, "R2");
        wr(4'd8, 32'h0, "R2");

        // R3: channel 1 byte lane data compare
        wr(4'd1, 32'h3000_0000, "R3");
        wr(4'd2, 32'h3, "R3");
        wr(4'd3, 32'hA5, "R3");
        wr(4'd4, 32'h0, "R3");
        wr(4'd0, mk_ctrl(1,0,0,0,0,0,0,0,2'd1,1), "R3");
        bus(32'h3000_0002, 32'h00A5_0000, 0, 0, "R3");
        bus(32'h3000_0002, 32'h0000_A500, 0, 0, "R3");
        bus(32'h3000_0002, 32'h00A5_00A5, 1, 0, "R3");
        wr(4'd0, mk_ctrl(1,0,0,0,0,0,0,0,2'd2,1), "R3");
        bus(32'h3000_0002, 32'h00A5_0000, 1, 0, "R3");
        wr(4'd0, 32'h0, "R3");

        // R4: direction, ASID, state on channel 2
        wr(4'd6, 32'h5000_0000, "R4");
        wr(4'd7, 32'h0, "R4");
        wr(4'd5, mk_ctrl(1,0,0,2'd2,1,8'h07,1,2'd3,0,0), "R4");
        cur_asid = 8'h07;
        idle(); bus_valid = 1; bus_addr = 32'h5000_0000; bus_wr = 1; bus_state = 3; tick("R4");
        idle(); bus_valid = 1; bus_addr = 32'h5000_0000; bus_wr = 0; bus_state = 3; tick("R4");
        idle(); bus_valid = 1; bus_addr = 32'h5000_0000; bus_wr = 1; bus_state = 1; tick("R4");
        cur_asid = 8'h08;
        idle(); bus_valid = 1; bus_addr = 32'h5000_0000; bus_wr = 1; bus_state = 3; tick("R4");
        cur_asid = 8'h00;
        wr(4'd5, 32'h0, "R4");

        // R5: event channel kinds
        wr(4'd14, 32'h1, "R5");
        idle(); tlb_load = 1; tick("R5");
        idle(); io_access = 1; tick("R5");
        wr(4'd14, 32'h3, "R5");
        idle(); io_access = 1; tick("R5");
        idle(); tlb_load = 1; tick("R5");
        wr(4'd14, 32'h0, "R5");

        // R7 R8: chain 3-2-1 with misordered hits
        wr(4'd1, 32'h6000_0001, "R7"); wr(4'd2, 32'h0, "R7");
        wr(4'd0, mk_ctrl(1,0,0,0,0,0,0,0,0,0), "R7");
        wr(4'd6, 32'h6000_0002, "R7"); wr(4'd7, 32'h0, "R7");
        wr(4'd5, mk_ctrl(1,0,0,0,0,0,0,0,0,0), "R7");
        wr(4'd9, 32'h6000_0003, "R7"); wr(4'd10, 32'h0, "R7");
        wr(4'd8, mk_ctrl(1,0,0,0,0,0,0,0,0,0), "R7");
        wr(4'd15, 32'h2, "R9");
        bus(32'h6000_0002, 0, 2, 0, "R8");
        bus(32'h6000_0001, 0, 2, 0, "R8");
        bus(32'h6000_0003, 0, 2, 0, "R7");
        bus(32'h6000_0001, 0, 2, 0, "R8");
        bus(32'h6000_0002, 0, 2, 0, "R7");
        bus(32'h6000_0001, 0, 2, 0, "R7");
        bus(32'h6000_0001, 0, 2, 0, "R9");

        // R9: mode write clears a half-done chain
        wr(4'd15, 32'h1, "R9");
        bus(32'h6000_0002, 0, 2, 0, "R9");
        wr(4'd15, 32'h1, "R9");
        bus(32'h6000_0001, 0, 2, 0, "R9");

        // R10: channel 5 and channel 4 outside a 3-2-1 chain
        wr(4'd15, 32'h2, "R10");
        wr(4'd14, 32'h1, "R10");
        idle(); tlb_load = 1; bus_valid = 1; bus_addr = 32'h6000_0001; tick("R10");
        wr(4'd12, 32'h6000_0004, "R10"); wr(4'd13, 32'h0, "R10");
        wr(4'd11, mk_ctrl(1,0,0,0,0,0,0,0,0,0), "R10");
        bus(32'h6000_0004, 0, 2, 0, "R10");

        // R7: full 4-3-2-1 chain
        wr(4'd14, 32'h0, "R7");
        wr(4'd15, 32'h3, "R7");
        bus(32'h6000_0004, 0, 2, 0, "R7");
        bus(32'h6000_0002, 0, 2, 0, "R8");
        bus(32'h6000_0003, 0, 2, 0, "R7");
        bus(32'h6000_0002, 0, 2, 0, "R7");
        bus(32'h6000_0001, 0, 2, 0, "R7");

        // Random traffic (R1 R2 R3 R4 R5 R6 R7 R10)
        for (int it = 0; it < 6000; it++) begin
            if ($urandom % 12 == 0) begin
                logic [3:0] a = 4'($urandom % 16);
                wr(a, rand_reg(a), "random cfg");
            end else begin
                idle();
                cur_asid  = 8'($urandom % 2);
                bus_valid = ($urandom % 3) != 0;
                bus_addr  = pool_addr();
                bus_data  = 32'($urandom % 4) * 32'h1111_1111;
                bus_size  = 2'($urandom % 3);
                bus_wr    = 1'($urandom);
                bus_state = 2'($urandom);
                ins_valid = ($urandom % 3) != 0;
                ins_pc    = pool_addr();
                ins_after = 1'($urandom);
                tlb_load  = ($urandom % 16) == 0;
                io_access = ($urandom % 16) == 0;
                tick("random R1 R6");
            end
        end

        summary();
        $finish;
    end
endmodule